// File: doc/BRIEF.md
# Write-Protected Pin Function Selector

This block holds one function-select byte per pin for a set of eight-pin ports. Each byte carries a function code that drives the pin multiplexing network, plus an interrupt-select flag. The network itself is outside this block. All bytes sit on a simple register bus. Software addresses a pin's byte directly from its port and pin number.

A protect register guards the function-select bytes against stray writes. It has two bits, a lock bit and an enable bit. The enable bit can only be changed by a write that arrives while the lock bit is already clear. Function-select writes take effect only while the enable bit is set. To open the bytes for writing, software writes 0x00 and then 0x40. To close them again, it writes 0x00 and then 0x80. Reads of every register are always allowed. Read data appears on the cycle after the read request.

Top module: `pin_func_guard`

## Requirements
- R1: After reset the protect register reads 0x80 (lock bit 7 set, enable bit 6 clear). Every function-select byte reads 0x00, and every pinFunc and pinIrqSel output is 0.
- R2: A read of the protect register at address PROT_ADDR (default 0x2FF) returns the lock bit in bit 7 and the enable bit in bit 6. Bits 5..0 read as 0.
- R3: A protect write made while the lock bit is 1 leaves the enable bit unchanged, even if data bit 6 is 1. Such a write still loads the lock bit from data bit 7.
- R4: The write 0x00 followed by the write 0x40 leaves the lock bit 0 and the enable bit 1, so the protect register reads 0x40.
- R5: While the enable bit is 0, a write to a function-select byte is dropped. The byte and its pin outputs keep their previous values.
- R6: While the enable bit is 1, a write to a function-select byte stores data bits 6..0. pinFunc for that pin then shows bits 5..0 and pinIrqSel shows bit 6, one cycle after the write. Bit 7 of the byte always reads 0.
- R7: From the open state, the write 0x00 followed by the write 0x80 returns the protect register to 0x80, and later function-select writes are dropped again.
- R8: The pin with index port*8+pin has its byte at FUNC_BASE+index (default FUNC_BASE 0x200). Its code appears on pinFunc bits [index*6 +: 6] and its flag on pinIrqSel bit index. A write touches only that pin.
- R9: A read of a function-select byte returns its stored value whatever the state of the protect register. Read data is valid on busRdata one cycle after the read request.
- R10: A read of an address that maps to no register returns 0x00. A write to such an address changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Bus request valid this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W (12) | Byte address |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, registered |
| pinFunc | output | NUM_PINS*6 (384) | Function code per pin, 6 bits each |
| pinIrqSel | output | NUM_PINS (64) | Interrupt-select flag per pin |

## Verification
The hardest state to reach from the ports is a protect write that sets data bit 6 while the lock bit is still 1. Such a write must not change the enable bit. A related case is the combined value 0xC0 written while unlocked, which leaves the lock and enable bits both set. Directed sequences create both cases. A random phase then mixes protect values 0x00, 0x40, 0x80, 0xC0 and arbitrary bytes with function-select writes and reads. The enable state therefore toggles often while writes arrive, and every dropped or accepted write is checked against the bench's model of the protect bits.

// File: rtl/pin_func_pkg.sv
package pin_func_pkg;
  localparam int FSEL_STORE_W = 7;  // function code [5:0] + irq select [6]
  localparam int FUNC_CODE_W  = 6;

  typedef struct packed {
    logic                    funcWe;
    logic [FSEL_STORE_W-1:0] data;
  } fsel_strobe_t;
endpackage

// File: rtl/fsel_ctrl.sv
module fsel_ctrl
  import pin_func_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NUM_PINS  = 64,
  parameter int IDX_W     = 6,
  parameter logic [ADDR_W-1:0] FUNC_BASE = 12'h200,
  parameter logic [ADDR_W-1:0] PROT_ADDR = 12'h2FF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWdata,
  input  logic [7:0]        rdByte,
  output logic [7:0]        busRdata,
  output fsel_strobe_t      st,
  output logic [IDX_W-1:0]  pinIdx
);
  logic              lockBit;
  logic              enBit;
  logic [ADDR_W-1:0] addrOffs;
  logic              hitFunc;
  logic              hitProt;
  logic              protWe;

  assign addrOffs = busAddr - FUNC_BASE;
  assign hitFunc  = (busAddr >= FUNC_BASE) && (addrOffs < ADDR_W'(NUM_PINS));
  assign hitProt  = (busAddr == PROT_ADDR);
  assign protWe   = busValid && busWrite && hitProt;
  assign pinIdx   = addrOffs[IDX_W-1:0];

  // protect register: enable may only move while lock is already clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockBit <= 1'b1;
      enBit   <= 1'b0;
    end else if (protWe) begin
      lockBit <= busWdata[7];
      if (!lockBit) enBit <= busWdata[6];
    end
  end

  always_comb begin
    st.funcWe = busValid && busWrite && hitFunc && enBit;
    st.data   = busWdata[FSEL_STORE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busRdata <= 8'h00;
    end else if (busValid && !busWrite) begin
      if (hitProt)      busRdata <= {lockBit, enBit, 6'b0};
      else if (hitFunc) busRdata <= rdByte;
      else              busRdata <= 8'h00;
    end
  end

  // R3: enable bit only changes when lock was clear on the previous cycle
  a_r3_enable_needs_unlock: assert property (@(posedge clk) disable iff (!rstN)
    (enBit != $past(enBit)) |-> !$past(lockBit));

  // R5: no function write strobe without the enable bit
  a_r5_write_gated: assert property (@(posedge clk) disable iff (!rstN)
    st.funcWe |-> enBit);

  // R2: protect read returns lock in bit 7, zeros in bits 5..0
  a_r2_prot_readback: assert property (@(posedge clk) disable iff (!rstN)
    $past(busValid && !busWrite && hitProt) |->
      (busRdata[5:0] == 6'b0) && (busRdata[7] == $past(lockBit)));

  // R10: unmapped read returns zero
  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rstN)
    $past(busValid && !busWrite && !hitProt && !hitFunc) |-> (busRdata == 8'h00));
endmodule

// File: rtl/fsel_datapath.sv
module fsel_datapath
  import pin_func_pkg::*;
#(
  parameter int NUM_PINS = 64,
  parameter int IDX_W    = 6
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  fsel_strobe_t                    st,
  input  logic [IDX_W-1:0]                pinIdx,
  output logic [7:0]                      rdByte,
  output logic [NUM_PINS*FUNC_CODE_W-1:0] pinFunc,
  output logic [NUM_PINS-1:0]             pinIrqSel
);
  logic [FSEL_STORE_W-1:0] fsel [NUM_PINS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_PINS; i++) fsel[i] <= '0;
    end else if (st.funcWe) begin
      fsel[pinIdx] <= st.data;
    end
  end

  assign rdByte = {1'b0, fsel[pinIdx]};

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    assign pinFunc[g*FUNC_CODE_W +: FUNC_CODE_W] = fsel[g][FUNC_CODE_W-1:0];
    assign pinIrqSel[g]                          = fsel[g][FUNC_CODE_W];
  end

  // R5: outputs hold when no accepted write
  a_r5_hold: assert property (@(posedge clk) disable iff (!rstN)
    !st.funcWe |=> ($stable(pinFunc) && $stable(pinIrqSel)));

  // R6: accepted write shows on the addressed pin's flag one cycle later
  a_r6_flag_update: assert property (@(posedge clk) disable iff (!rstN)
    st.funcWe |=> (pinIrqSel[$past(pinIdx)] == $past(st.data[FUNC_CODE_W])));
endmodule

// File: rtl/pin_func_guard.sv
module pin_func_guard
  import pin_func_pkg::*;
#(
  parameter int NUM_PORTS     = 8,
  parameter int PINS_PER_PORT = 8,
  parameter int ADDR_W        = 12,
  parameter logic [ADDR_W-1:0] FUNC_BASE = 12'h200,
  parameter logic [ADDR_W-1:0] PROT_ADDR = 12'h2FF,
  localparam int NUM_PINS = NUM_PORTS * PINS_PER_PORT,
  localparam int IDX_W    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            busValid,
  input  logic                            busWrite,
  input  logic [ADDR_W-1:0]               busAddr,
  input  logic [7:0]                      busWdata,
  output logic [7:0]                      busRdata,
  output logic [NUM_PINS*FUNC_CODE_W-1:0] pinFunc,
  output logic [NUM_PINS-1:0]             pinIrqSel
);
  fsel_strobe_t     st;
  logic [IDX_W-1:0] pinIdx;
  logic [7:0]       rdByte;

  fsel_ctrl #(
    .ADDR_W(ADDR_W), .NUM_PINS(NUM_PINS), .IDX_W(IDX_W),
    .FUNC_BASE(FUNC_BASE), .PROT_ADDR(PROT_ADDR)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .rdByte(rdByte),
    .busRdata(busRdata), .st(st), .pinIdx(pinIdx)
  );

  fsel_datapath #(
    .NUM_PINS(NUM_PINS), .IDX_W(IDX_W)
  ) i_data (
    .clk(clk), .rstN(rstN), .st(st), .pinIdx(pinIdx), .rdByte(rdByte),
    .pinFunc(pinFunc), .pinIrqSel(pinIrqSel)
  );
endmodule

// File: tb/test_pin_func_guard.sv
module test_pin_func_guard;
  localparam int CLK_PERIOD = 10;
  localparam int NPINS = 64;
  localparam logic [11:0] FBASE = 12'h200;
  localparam logic [11:0] PADDR = 12'h2FF;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [11:0] busAddr = '0;
  logic [7:0]  busWdata = '0;
  logic [7:0]  busRdata;
  logic [NPINS*6-1:0] pinFunc;
  logic [NPINS-1:0]   pinIrqSel;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic       expLock;
  logic       expEn;
  logic [6:0] expMem [NPINS];

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_func_guard i_pin_func_guard (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .pinFunc(pinFunc), .pinIrqSel(pinIrqSel)
  );

  function automatic logic [7:0] protByte();
    return {expLock, expEn, 6'b0};
  endfunction

  function automatic logic [7:0] funcByte(int idx);
    return {1'b0, expMem[idx]};
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic busWr(logic [11:0] a, logic [7:0] d);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
    if (a == PADDR) begin
      if (!expLock) expEn = d[6];
      expLock = d[7];
    end else if (a >= FBASE && a < FBASE + NPINS && expEn) begin
      expMem[a - FBASE] = d[6:0];
    end
  endtask

  task automatic busRd(logic [11:0] a, logic [7:0] exp, string tag);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b0; busAddr = a;
    @(negedge clk);
    busValid = 1'b0;
    check(tag, busRdata, exp);
  endtask

  task automatic checkPin(int idx, string tag);
    check(tag, {2'b0, pinFunc[idx*6 +: 6]}, {2'b0, expMem[idx][5:0]});
    check(tag, {7'b0, pinIrqSel[idx]}, {7'b0, expMem[idx][6]});
  endtask

  initial begin
    int errBefore;
    void'($urandom(32'd20240611));
    expLock = 1'b1; expEn = 1'b0;
    for (int i = 0; i < NPINS; i++) expMem[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    busRd(PADDR, 8'h80, "R1 protect reset");
    busRd(FBASE + 12'd5, 8'h00, "R1 fsel reset");
    check("R1 outputs reset", {7'b0, |{pinFunc, pinIrqSel}}, 8'h00);

    // R5 write while locked dropped
    busWr(FBASE + 12'd3, 8'h55);
    busRd(FBASE + 12'd3, funcByte(3), "R5 locked write dropped");
    checkPin(3, "R5 pin held");

    // R3 0xC0 while locked: enable stays 0
    busWr(PADDR, 8'hC0);
    busRd(PADDR, 8'h80, "R3 enable blocked while locked");
    // R3 0x40 while locked: lock clears, enable still 0
    busWr(PADDR, 8'h40);
    busRd(PADDR, 8'h00, "R3 lock cleared enable unchanged");

    // R4 proper unlock
    busWr(PADDR, 8'h00);
    busWr(PADDR, 8'h40);
    busRd(PADDR, 8'h40, "R4 unlocked");
    check("R2 model agrees", protByte(), 8'h40);

    // R6 and R8 accepted write, neighbours untouched
    busWr(FBASE + 12'd9, 8'hFF);
    busRd(FBASE + 12'd9, 8'h7F, "R6 bit7 reads zero");
    checkPin(9, "R6 pin outputs");
    busRd(FBASE + 12'd8, 8'h00, "R8 neighbour below");
    busRd(FBASE + 12'd10, 8'h00, "R8 neighbour above");
    busWr(FBASE + 12'd63, 8'h2A);
    checkPin(63, "R8 last pin");

    // R10 unmapped
    busWr(FBASE + 12'd64, 8'h11);
    busRd(FBASE + 12'd64, 8'h00, "R10 unmapped read");
    busRd(12'h1FF, 8'h00, "R10 below base");

    // R7 relock
    busWr(PADDR, 8'h00);
    busWr(PADDR, 8'h80);
    busRd(PADDR, 8'h80, "R7 relocked");
    busWr(FBASE + 12'd9, 8'h01);
    busRd(FBASE + 12'd9, 8'h7F, "R7 write after relock dropped");
    // R9 read while locked
    busRd(FBASE + 12'd63, 8'h2A, "R9 read while locked");

    // R2 corner: 0xC0 while unlocked sets both
    busWr(PADDR, 8'h00);
    busWr(PADDR, 8'hC0);
    busRd(PADDR, 8'hC0, "R2 lock and enable both set");
    busWr(FBASE + 12'd20, 8'h47);
    checkPin(20, "R6 write with lock set but enable set");

    // random phase
    for (int n = 0; n < 600; n++) begin
      int op = $urandom_range(0, 9);
      int idx = $urandom_range(0, NPINS - 1);
      logic [7:0] d = 8'($urandom);
      case (op)
        0, 1: begin
          int k = $urandom_range(0, 4);
          logic [7:0] pv = (k == 0) ? 8'h00 : (k == 1) ? 8'h40 :
                           (k == 2) ? 8'h80 : (k == 3) ? 8'hC0 : d;
          busWr(PADDR, pv);
        end
        2: busRd(PADDR, protByte(), "R2 random protect read");
        3, 4, 5: begin
          busWr(FBASE + 12'(idx), d);
          checkPin(idx, expEn ? "R6 random accepted" : "R5 random dropped");
        end
        6, 7: busRd(FBASE + 12'(idx), funcByte(idx), "R9 random read");
        8: busWr(12'h300 + 12'(idx), d);
        default: busRd(12'h100 + 12'(idx), 8'h00, "R10 random unmapped");
      endcase
    end
    errBefore = fails;
    for (int i = 0; i < NPINS; i++) checkPin(i, "R8 final sweep");
    if (fails != errBefore) $display("final sweep mismatches: %0d", fails - errBefore);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule